// File: doc/BRIEF.md
# Burst Address Sequencer

This block turns one captured word address into a four-beat burst of addresses for a synchronous memory. When either of two start strobes is sampled high on a rising clock edge, the block stores the word address presented on its input and marks its output valid. The first beat is the stored address itself. After that, each clock edge on which the advance input is high steps a 2-bit beat counter. That counter drives only the two low address bits. The upper bits stay fixed for the rest of the burst.

One start strobe belongs to the processor side and only counts while the chip-select input is high. The other belongs to the controller side and does not depend on chip-select. A static order input chooses how the low bits move. In linear order they count up from the start value, modulo four. In interleaved order they are the start value XORed with the beat number. A new strobe loads a fresh address and restarts the burst at beat zero, even if the current burst has not finished. All inputs are sampled on the rising clock edge, and the outputs come straight from registers through a small piece of combinational logic.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is high and on the first edge after it, `addr_valid` is 0 and `cur_addr` is all zeros.
- R2: A rising edge with `proc_strobe`=1 and `chip_sel`=1 loads `start_addr`. From the next sample on, `cur_addr` equals that address and `addr_valid` is 1.
- R3: A rising edge with `proc_strobe`=1, `chip_sel`=0 and `ctrl_strobe`=0 loads nothing. `cur_addr` and `addr_valid` keep the values they had before that edge.
- R4: A rising edge with `ctrl_strobe`=1 loads `start_addr` whatever the value of `chip_sel`. When both strobes are high on the same edge, exactly one load of `start_addr` takes place.
- R5: With `order_sel`=0 (linear), beat k of a burst has low bits `cur_addr[1:0]` = (start low bits + k) mod 4.
- R6: With `order_sel`=1 (interleaved), beat k has low bits `cur_addr[1:0]` = start low bits XOR k.
- R7: An edge with no accepted strobe and `advance`=0 leaves `cur_addr` unchanged.
- R8: After the fourth beat, one more advance brings the burst back to beat 0, which is the start address. Bits `cur_addr[ADDR_W-1:2]` never change except on a load.
- R9: A strobe accepted in the middle of a burst loads the new address and restarts the burst at beat 0.
- R10: Before any load has happened, `advance` has no effect: `cur_addr` stays zero and `addr_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| proc_strobe | input | 1 | Processor-side start strobe; accepted only when `chip_sel` is high |
| ctrl_strobe | input | 1 | Controller-side start strobe |
| chip_sel | input | 1 | Chip select, active high; enables the processor-side strobe |
| advance | input | 1 | Step to the next beat of the burst |
| order_sel | input | 1 | Burst order: 0 = linear, 1 = interleaved |
| start_addr | input | ADDR_W | Word address captured by an accepted strobe |
| cur_addr | output | ADDR_W | Address of the current beat |
| addr_valid | output | 1 | High once an address has been loaded since reset |

## Verification
The bench starts linear bursts at low bits 1 and 3, so the sequence has to wrap inside the four-word block. A design that let the beat counter carry into the upper bits would show a changed upper address on the wrap beat. It also runs interleaved bursts from two different start values, where a design that added the beat instead of XORing it would give 1,2,3,0 in place of 1,0,3,2. It drives the processor strobe with chip-select low, and it leaves `advance` low between steps. A design that ignored the gate, or that advanced on every edge, would show a new address at those samples. It also restarts a burst partway through, and it pulses `advance` before any load, to catch a counter that is not reset to beat 0 on a load or that runs while the output is not yet valid.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
    localparam int BEAT_W = 2;

    typedef enum logic {
        ORDER_LINEAR = 1'b0,
        ORDER_XOR    = 1'b1
    } order_e;

    typedef logic [BEAT_W-1:0] beat_t;

    // Low address bits for a given beat of the burst
    function automatic beat_t beat_order(order_e mode, beat_t first, beat_t beat);
        beat_t r;
        if (mode == ORDER_XOR) r = first ^ beat;
        else                   r = first + beat;
        return r;
    endfunction
endpackage

// File: rtl/bseq_strobe_gate.sv
module bseq_strobe_gate (
    input  logic proc_strobe,
    input  logic ctrl_strobe,
    input  logic chip_sel,
    output logic load
);
    logic proc_ok;

    // processor-side strobe only counts while the chip is selected
    always_comb begin
        proc_ok = proc_strobe & chip_sel;
        load    = proc_ok | ctrl_strobe;
    end
endmodule

// File: rtl/bseq_addr_reg.sv
module bseq_addr_reg #(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] start_addr,
    output logic [ADDR_W-1:0] base,
    output logic              valid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            base  <= '0;
            valid <= 1'b0;
        end else if (load) begin
            base  <= start_addr;
            valid <= 1'b1;
        end
    end
endmodule

// File: rtl/bseq_beat_cnt.sv
module bseq_beat_cnt
    import bseq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  logic  valid,
    input  logic  advance,
    output beat_t beat
);
    // wraps modulo four; never carries beyond its own width
    always_ff @(posedge clk) begin
        if (rst || load)           beat <= '0;
        else if (valid && advance) beat <= beat + beat_t'(1);
    end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import bseq_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              proc_strobe,
    input  logic              ctrl_strobe,
    input  logic              chip_sel,
    input  logic              advance,
    input  logic              order_sel,
    input  logic [ADDR_W-1:0] start_addr,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              addr_valid
);
    localparam int HI_W = ADDR_W - BEAT_W;

    logic              load;
    logic [ADDR_W-1:0] base;
    logic              valid;
    beat_t             beat;
    order_e            mode;

    bseq_strobe_gate u_gate (
        .proc_strobe (proc_strobe),
        .ctrl_strobe (ctrl_strobe),
        .chip_sel    (chip_sel),
        .load        (load)
    );

    bseq_addr_reg #(.ADDR_W(ADDR_W)) u_areg (
        .clk        (clk),
        .rst        (rst),
        .load       (load),
        .start_addr (start_addr),
        .base       (base),
        .valid      (valid)
    );

    bseq_beat_cnt u_cnt (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .valid   (valid),
        .advance (advance),
        .beat    (beat)
    );

    always_comb begin
        mode       = order_e'(order_sel);
        cur_addr   = {base[ADDR_W-1 -: HI_W],
                      beat_order(mode, base[BEAT_W-1:0], beat)};
        addr_valid = valid;
    end
endmodule

// File: rtl/bseq_checker.sv
module bseq_checker #(
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst,
    input logic              proc_strobe,
    input logic              ctrl_strobe,
    input logic              chip_sel,
    input logic              advance,
    input logic              order_sel,
    input logic [ADDR_W-1:0] start_addr,
    input logic [ADDR_W-1:0] cur_addr,
    input logic              addr_valid
);
    logic acc;
    assign acc = (proc_strobe && chip_sel) || ctrl_strobe;

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!addr_valid && cur_addr == '0));

    assert_proc_load_R2: assert property (@(posedge clk) disable iff (rst)
        (proc_strobe && chip_sel) |=> (addr_valid && cur_addr == $past(start_addr)));

    assert_gated_proc_R3: assert property (@(posedge clk) disable iff (rst)
        (proc_strobe && !chip_sel && !ctrl_strobe && !advance)
        |=> (cur_addr == $past(cur_addr) && addr_valid == $past(addr_valid)));

    assert_ctrl_load_R4: assert property (@(posedge clk) disable iff (rst)
        ctrl_strobe |=> (addr_valid && cur_addr == $past(start_addr)));

    assert_linear_step_R5: assert property (@(posedge clk) disable iff (rst)
        (!acc && addr_valid && advance && !order_sel && !$isunknown(cur_addr))
        |=> (cur_addr[1:0] == 2'($past(cur_addr[1:0]) + 2'd1)));

    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!acc && !advance) |=> $stable(cur_addr));

    assert_upper_fixed_R8: assert property (@(posedge clk) disable iff (rst)
        !acc |=> (cur_addr[ADDR_W-1:2] == $past(cur_addr[ADDR_W-1:2])));

    assert_idle_advance_R10: assert property (@(posedge clk) disable iff (rst)
        (!addr_valid && !acc) |=> (!addr_valid && $stable(cur_addr)));
endmodule

bind burst_addr_seq bseq_checker #(.ADDR_W(ADDR_W)) u_bseq_chk (
    .clk         (clk),
    .rst         (rst),
    .proc_strobe (proc_strobe),
    .ctrl_strobe (ctrl_strobe),
    .chip_sel    (chip_sel),
    .advance     (advance),
    .order_sel   (order_sel),
    .start_addr  (start_addr),
    .cur_addr    (cur_addr),
    .addr_valid  (addr_valid)
);

// File: tb/test_burst_addr_seq.sv
`timescale 1ns/1ps
module test_burst_addr_seq;
    localparam int AW = 20;

    logic          clk = 1'b0;
    logic          rst;
    logic          proc_strobe, ctrl_strobe, chip_sel, advance, order_sel;
    logic [AW-1:0] start_addr;
    logic [AW-1:0] cur_addr;
    logic          addr_valid;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW)) i_burst_addr_seq (
        .clk (clk), .rst (rst), .proc_strobe (proc_strobe),
        .ctrl_strobe (ctrl_strobe), .chip_sel (chip_sel), .advance (advance),
        .order_sel (order_sel), .start_addr (start_addr),
        .cur_addr (cur_addr), .addr_valid (addr_valid)
    );

    task automatic check(input string req, input logic [AW-1:0] act,
                         input logic [AW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        proc_strobe = 0; ctrl_strobe = 0; advance = 0;
    endtask

    // one rising edge, then settle before sampling
    task automatic step();
        @(posedge clk); #2;
        idle();
    endtask

    task automatic load_proc(input logic [AW-1:0] a);
        start_addr = a; chip_sel = 1; proc_strobe = 1; step();
    endtask

    task automatic t_reset();
        rst = 1; idle(); chip_sel = 1; order_sel = 0; start_addr = '0;
        step(); step();
        check("R1 valid", AW'(addr_valid), '0);
        check("R1 addr", cur_addr, '0);
        rst = 0;
    endtask

    task automatic t_idle_advance();
        for (int i = 0; i < 3; i++) begin advance = 1; step(); end
        check("R10 valid", AW'(addr_valid), '0);
        check("R10 addr", cur_addr, '0);
    endtask

    task automatic t_linear(input logic [AW-1:0] a);
        order_sel = 0;
        load_proc(a);
        check("R2 valid", AW'(addr_valid), AW'(1));
        check("R2 addr", cur_addr, a);
        for (int k = 1; k <= 4; k++) begin
            advance = 1; step();
            check("R5/R8 linear", cur_addr,
                  {a[AW-1:2], 2'(a[1:0] + 2'(k))});
        end
    endtask

    task automatic t_interleave(input logic [AW-1:0] a);
        order_sel = 1;
        ctrl_strobe = 1; chip_sel = 0; start_addr = a; step();
        check("R4 ctrl load", cur_addr, a);
        for (int k = 1; k <= 4; k++) begin
            advance = 1; step();
            check("R6/R8 interleaved", cur_addr,
                  {a[AW-1:2], a[1:0] ^ 2'(k)});
        end
    endtask

    task automatic t_hold_and_gate();
        logic [AW-1:0] snap;
        order_sel = 0;
        load_proc(20'h3C5A2);
        advance = 1; step();
        snap = cur_addr;
        step(); step();
        check("R7 hold", cur_addr, snap);
        chip_sel = 0; proc_strobe = 1; start_addr = 20'h11110; step();
        check("R3 gated addr", cur_addr, snap);
        check("R3 gated valid", AW'(addr_valid), AW'(1));
    endtask

    task automatic t_reload();
        order_sel = 0;
        load_proc(20'h00001);
        advance = 1; step();
        advance = 1; step();
        check("R9 mid", cur_addr, 20'h00003);
        load_proc(20'h7FFF2);
        check("R9 reload", cur_addr, 20'h7FFF2);
        advance = 1; step();
        check("R9 restart", cur_addr, 20'h7FFF3);
        chip_sel = 1; proc_strobe = 1; ctrl_strobe = 1;
        start_addr = 20'h2A2A1; step();
        check("R4 both strobes", cur_addr, 20'h2A2A1);
        advance = 1; step();
        check("R4 both then step", cur_addr, 20'h2A2A2);
    endtask

    initial begin
        t_reset();
        t_idle_advance();
        t_linear(20'hABCD1);
        t_linear(20'h12343);
        t_interleave(20'h55551);
        t_interleave(20'h0F0F2);
        t_hold_and_gate();
        t_reload();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        end
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        end
        $finish;
    end
endmodule